// File: doc/BRIEF.md
# Multichannel ADC Serial Read Controller

This block is the clock-generating host for a 14-bit converter with a serial output, placed behind an external four-way analog multiplexer. Each read starts when the block drives chip select low, which also begins the conversion. It then toggles a serial clock at a programmed rate and shifts in a 24-bit frame: eight zero bits, the 14-bit result with the most significant bit first, and two trailing sub-bits. It then raises chip select and presents the result with a one-cycle strobe.

The multiplexer address lines are part of the same sequence. One system clock after chip select falls, the block moves them to the next channel in a programmed four-slot sequence. The selected input then has almost the whole frame to slew and settle before the next conversion begins. Each result is tagged with the channel that was selected when its conversion started. A start request held high produces back-to-back reads. A minimum chip-select-high gap always separates two reads.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `mux_sel` is 0 and `res_valid` is 0.
- R2: With the block idle and `start_req` high at a clock edge, `adc_cs_n` goes low at that edge. Exactly 24 rising edges of `adc_sclk` then occur while `adc_cs_n` stays low.
- R3: The serial clock half period H, in system clocks, equals `sclk_div` clamped into [21, 1000] at the 200 MHz default. These bounds keep the serial clock within 100 kHz to 4.8 MHz. The first rising edge comes H cycles after chip select falls, and each later rising edge comes 2H cycles after the previous one.
- R4: `adc_sdo` is sampled at each rising edge of `adc_sclk`. Frame bit k (k = 0..23) is the value at rising edge k+1. Bits 0..7 are the leading zeros, bits 8..21 form `res_data` from bit 13 down to bit 0, and bits 22 and 23 form `res_sub[1]` and `res_sub[0]`.
- R5: `adc_cs_n` rises at the same edge as the 24th falling edge of `adc_sclk`, which is 48H cycles after it fell. `res_valid` is high for exactly that one cycle, and the result fields are valid with it.
- R6: `adc_cs_n` stays high for at least 11 system clocks (at least 50 ns) before it falls again, even while `start_req` is held high.
- R7: Slot k of the sequence is `ch_seq[2k+1:2k]`. One cycle after `adc_cs_n` falls, `mux_sel` takes the slot at the current sequence pointer, and the pointer then advances modulo 4 (it resets to slot 0). `mux_sel` changes at no other time. `res_chan` reports the value `mux_sel` held when chip select fell.
- R8: `res_lead_err` is 1 when any of the eight leading bits is 1, and `res_data` and `res_sub` are delivered unchanged either way.
- R9: `adc_sclk` is low whenever `adc_cs_n` is high.
- R10: `sclk_div` and `ch_seq` are captured when a read starts. Changes to them during the frame have no effect on that frame's timing or on its mux address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Read request; held high, it repeats reads |
| ch_seq | input | 8 | Four 2-bit channel slots, slot 0 in the low bits |
| sclk_div | input | 10 | Requested serial clock half period in system clocks |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| mux_sel | output | 2 | External multiplexer address |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 14 | Conversion result |
| res_sub | output | 2 | Sub-bits S1 (bit 1) and S0 (bit 0) |
| res_chan | output | 2 | Channel converted for this result |
| res_lead_err | output | 1 | A leading bit was nonzero |

## Verification
Counted from the clock edge that lowers chip select, `mux_sel` is due one cycle later. The first serial clock rise is due H cycles later and each further rise 2H after the one before. Chip select rise and `res_valid` are both due at exactly 48H, and the next chip select fall no sooner than 11 cycles after that. The driver counts cycles from the falling edge of chip select and compares every edge with these positions. A converter model shifts a frame word on each falling serial clock. The scoreboard monitor pops the expected result, fields and channel when the strobe appears, and checks that chip select rose in that same cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int LEAD_BITS  = 8;
    localparam int DATA_BITS  = 14;
    localparam int SUB_BITS   = 2;
    localparam int FRAME_BITS = LEAD_BITS + DATA_BITS + SUB_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_e;

    function automatic int ceil_div(input longint num, input longint den);
        return int'((num + den - 1) / den);
    endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    if (i == 0) chain_q[i] <= din;
                    else        chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adc_half_clamp.sv
module adc_half_clamp #(
    parameter int DIV_W    = 10,
    parameter int MIN_HALF = 21,
    parameter int MAX_HALF = 1000
) (
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] half_out
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_HALF);

    always_comb begin
        if (div_in < LO)      half_out = LO;
        else if (div_in > HI) half_out = HI;
        else                  half_out = div_in;
    end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
    import adc_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift_en,
    input  logic                 din,
    output logic [DATA_BITS-1:0] data,
    output logic [SUB_BITS-1:0]  sub,
    output logic                 lead_err
);
    logic [FRAME_BITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr)           sr_d = '0;
        else if (shift_en) sr_d = {sr_q[FRAME_BITS-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sub      = sr_q[SUB_BITS-1:0];
    assign data     = sr_q[SUB_BITS +: DATA_BITS];
    assign lead_err = |sr_q[FRAME_BITS-1 -: LEAD_BITS];
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int SCLK_MAX_HZ = 4_800_000,
    parameter int SCLK_MIN_HZ = 100_000,
    parameter int GAP_NS      = 50,
    parameter int DIV_W       = 10,
    parameter int CH_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req,
    input  logic [(1<<CH_W)*CH_W-1:0] ch_seq,
    input  logic [DIV_W-1:0]         sclk_div,
    input  logic                     adc_sdo,
    output logic                     adc_cs_n,
    output logic                     adc_sclk,
    output logic [CH_W-1:0]          mux_sel,
    output logic                     res_valid,
    output logic [13:0]              res_data,
    output logic [1:0]               res_sub,
    output logic [CH_W-1:0]          res_chan,
    output logic                     res_lead_err
);
    localparam int MIN_HALF = ceil_div(longint'(CLK_HZ), 2 * longint'(SCLK_MAX_HZ));
    localparam int MAX_HALF = CLK_HZ / (2 * SCLK_MIN_HZ);
    localparam int GAP_CYC  = ceil_div(longint'(CLK_HZ) * GAP_NS, 64'd1_000_000_000);
    localparam int GAP_W    = $clog2(GAP_CYC + 1);
    localparam int BIT_W    = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        rd_state_e            st;
        logic                 cs_n;
        logic                 sclk;
        logic [DIV_W-1:0]     half;
        logic [DIV_W-1:0]     hcnt;
        logic [BIT_W-1:0]     nbits;
        logic [GAP_W-1:0]     gcnt;
        logic [CH_W-1:0]      mux;
        logic [CH_W-1:0]      mux_next;
        logic                 mux_pend;
        logic [CH_W-1:0]      slot;
        logic [CH_W-1:0]      conv_ch;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
        logic [SUB_BITS-1:0]  sub;
        logic [CH_W-1:0]      chan;
        logic                 err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 sdo_s;
    logic [DIV_W-1:0]     half_lim;
    logic                 sh_clr, sh_en;
    logic [DATA_BITS-1:0] fr_data;
    logic [SUB_BITS-1:0]  fr_sub;
    logic                 fr_err;

    adc_bit_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_sdo),
        .dout  (sdo_s)
    );

    adc_half_clamp #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF),
        .MAX_HALF (MAX_HALF)
    ) i_clamp (
        .div_in   (sclk_div),
        .half_out (half_lim)
    );

    adc_frame_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .shift_en (sh_en),
        .din      (sdo_s),
        .data     (fr_data),
        .sub      (fr_sub),
        .lead_err (fr_err)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        sh_clr      = 1'b0;
        sh_en       = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    ctl_d.st       = ST_FRAME;
                    ctl_d.cs_n     = 1'b0;
                    ctl_d.sclk     = 1'b0;
                    ctl_d.half     = half_lim;
                    ctl_d.hcnt     = '0;
                    ctl_d.nbits    = '0;
                    ctl_d.conv_ch  = ctl_q.mux;
                    ctl_d.mux_next = ch_seq[ctl_q.slot*CH_W +: CH_W];
                    ctl_d.mux_pend = 1'b1;
                    ctl_d.slot     = ctl_q.slot + 1'b1;
                    sh_clr         = 1'b1;
                end
            end
            ST_FRAME: begin
                if (ctl_q.mux_pend) begin
                    ctl_d.mux      = ctl_q.mux_next;
                    ctl_d.mux_pend = 1'b0;
                end
                if (ctl_q.hcnt == ctl_q.half - 1'b1) begin
                    ctl_d.hcnt = '0;
                    if (!ctl_q.sclk) begin
                        ctl_d.sclk  = 1'b1;
                        ctl_d.nbits = ctl_q.nbits + 1'b1;
                        sh_en       = 1'b1;
                    end else begin
                        ctl_d.sclk = 1'b0;
                        if (ctl_q.nbits == BIT_W'(FRAME_BITS)) begin
                            ctl_d.cs_n  = 1'b1;
                            ctl_d.st    = ST_GAP;
                            ctl_d.gcnt  = '0;
                            ctl_d.valid = 1'b1;
                            ctl_d.data  = fr_data;
                            ctl_d.sub   = fr_sub;
                            ctl_d.err   = fr_err;
                            ctl_d.chan  = ctl_q.conv_ch;
                        end
                    end
                end else begin
                    ctl_d.hcnt = ctl_q.hcnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (ctl_q.gcnt == GAP_W'(GAP_CYC - 1)) ctl_d.st = ST_IDLE;
                else                                   ctl_d.gcnt = ctl_q.gcnt + 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign adc_cs_n     = ctl_q.cs_n;
    assign adc_sclk     = ctl_q.sclk;
    assign mux_sel      = ctl_q.mux;
    assign res_valid    = ctl_q.valid;
    assign res_data     = ctl_q.data;
    assign res_sub      = ctl_q.sub;
    assign res_chan     = ctl_q.chan;
    assign res_lead_err = ctl_q.err;
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk #(
    parameter int CH_W       = 2,
    parameter int GAP_CYC    = 10,
    parameter int MIN_HALF   = 21,
    parameter int FRAME_BITS = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adc_cs_n,
    input logic            adc_sclk,
    input logic [CH_W-1:0] mux_sel,
    input logic            res_valid
);
    logic [15:0] hi_run_q;
    logic [15:0] lvl_run_q;
    logic [7:0]  rise_q;
    logic        sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q    <= 16'(GAP_CYC);
            lvl_run_q   <= 16'(MIN_HALF);
            rise_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= adc_sclk;
            if (adc_cs_n) hi_run_q <= (hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 1'b1;
            else          hi_run_q <= '0;
            if (adc_sclk != sclk_prev_q) lvl_run_q <= 16'd1;
            else if (lvl_run_q != 16'hFFFF) lvl_run_q <= lvl_run_q + 1'b1;
            if (adc_cs_n)                         rise_q <= '0;
            else if (adc_sclk && !sclk_prev_q)    rise_q <= rise_q + 1'b1;
        end
    end

    assert_sclk_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    assert_valid_with_cs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));

    assert_valid_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_rise_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (rise_q == 8'(FRAME_BITS)));

    assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hi_run_q >= 16'(GAP_CYC)));

    assert_half_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk != sclk_prev_q) |-> (lvl_run_q >= 16'(MIN_HALF)));

    assert_mux_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel)) |-> (!$past(adc_cs_n) && $past(adc_cs_n, 2)));
endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(
    .CH_W     (CH_W),
    .GAP_CYC  (GAP_CYC),
    .MIN_HALF (MIN_HALF)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .mux_sel   (mux_sel),
    .res_valid (res_valid)
);

// File: tb/test_adc_read_ctrl.sv
module test_adc_read_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [7:0]  ch_seq = 8'h00;
    logic [9:0]  sclk_div = 10'd25;
    logic        adc_sdo = 1'b0;
    logic        adc_cs_n, adc_sclk, res_valid, res_lead_err;
    logic [1:0]  mux_sel, res_sub, res_chan;
    logic [13:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_read_ctrl i_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .ch_seq(ch_seq),
        .sclk_div(sclk_div), .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .mux_sel(mux_sel), .res_valid(res_valid),
        .res_data(res_data), .res_sub(res_sub), .res_chan(res_chan),
        .res_lead_err(res_lead_err)
    );

    typedef struct {
        logic [1:0]  chan;
        logic [13:0] data;
        logic [1:0]  sub;
        logic        err;
    } exp_t;

    exp_t        sb_q[$];
    logic [23:0] word_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter model: first bit on chip select fall, next bit on each sclk fall
    logic [23:0] cur_word = '0;
    int          bit_idx  = 0;
    always @(negedge adc_cs_n) begin
        if (word_q.size() > 0) cur_word = word_q.pop_front();
        else                   cur_word = '0;
        adc_sdo = cur_word[23];
        bit_idx = 22;
    end
    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            adc_sdo = (bit_idx >= 0) ? cur_word[bit_idx] : 1'b0;
            bit_idx--;
        end
    end

    // scoreboard monitor
    logic prev_cs = 1'b1, prev_val = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                chk(prev_cs == 1'b0 && adc_cs_n == 1'b1, "R5", "valid with cs rise", adc_cs_n, 1);
                chk(!prev_val, "R5", "valid width", prev_val, 0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(res_data == e.data, "R4", "data", res_data, e.data);
                    chk(res_sub == e.sub, "R4", "sub bits", res_sub, e.sub);
                    chk(res_chan == e.chan, "R7", "channel", res_chan, e.chan);
                    chk(res_lead_err == e.err, "R8", "lead error", res_lead_err, e.err);
                end
            end
            prev_cs  <= adc_cs_n;
            prev_val <= res_valid;
        end
    end

    // gap and idle-clock monitor
    int hi_cnt = 1000;
    bit sclk_in_idle = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_cs_n) begin
                hi_cnt++;
                if (adc_sclk) sclk_in_idle = 1'b1;
            end else if (hi_cnt > 0) begin
                chk(hi_cnt >= 11, "R6", "cs high gap", hi_cnt, 11);
                chk(!sclk_in_idle, "R9", "sclk low while cs high", sclk_in_idle, 0);
                hi_cnt = 0;
            end
        end
    end

    logic [1:0] mux_exp = 2'd0;
    int         slot    = 0;

    task automatic do_frame(input int div, input logic [23:0] word, input bit hold,
                            input logic [7:0] seq, input logic [7:0] seq_late);
        int h, cyc, rises, last;
        logic prev;
        logic [1:0] old_mux;
        exp_t e;
        h = (div < 21) ? 21 : (div > 1000) ? 1000 : div;
        ch_seq   = seq;
        sclk_div = 10'(div);
        e.chan = mux_exp; e.data = word[15:2]; e.sub = word[1:0]; e.err = |word[23:16];
        sb_q.push_back(e);
        word_q.push_back(word);
        old_mux = mux_exp;
        mux_exp = seq[slot*2 +: 2];
        slot    = (slot + 1) % 4;
        start_req = 1'b1;
        do @(negedge clk); while (adc_cs_n !== 1'b0);
        chk(mux_sel == old_mux, "R7", "mux held at cs fall", mux_sel, old_mux);
        chk(adc_sclk == 1'b0, "R2", "sclk low at cs fall", adc_sclk, 0);
        if (!hold) start_req = 1'b0;
        sclk_div = 10'(div) ^ 10'h2A5;   // R10: late change must not matter
        ch_seq   = seq_late;
        cyc = 0; rises = 0; last = 0; prev = 1'b0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (adc_cs_n) break;
            if (cyc == 1) chk(mux_sel == mux_exp, "R7", "mux switched", mux_sel, mux_exp);
            if (adc_sclk && !prev) begin
                rises++;
                if (rises == 1) chk(cyc == h, "R3", "first rise", cyc, h);
                else            chk(cyc - last == 2*h, "R10", "rise spacing", cyc - last, 2*h);
                last = cyc;
            end
            prev = adc_sclk;
        end
        chk(rises == 24, "R2", "rising edges", rises, 24);
        chk(cyc == 48*h, "R5", "cs rise time", cyc, 48*h);
        chk(adc_sclk == 1'b0, "R9", "sclk low at cs rise", adc_sclk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "cs after reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1", "sclk after reset", adc_sclk, 0);
        chk(mux_sel == 2'd0, "R1", "mux after reset", mux_sel, 0);
        chk(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
        // slots: 0->1, 1->2, 2->3, 3->0
        do_frame(25,   {8'h00, 14'h2ABC, 2'b10}, 1'b0, 8'h39, 8'hFF);
        do_frame(0,    {8'h00, 14'h3FFF, 2'b11}, 1'b0, 8'h39, 8'h00); // R3 lower clamp
        do_frame(30,   {8'h80, 14'h0001, 2'b01}, 1'b0, 8'h39, 8'hC6); // R8
        do_frame(22,   {8'h00, 14'h1555, 2'b00}, 1'b1, 8'h39, 8'hFF); // R6 held start
        do_frame(22,   {8'h01, 14'h0000, 2'b10}, 1'b1, 8'h39, 8'h00);
        do_frame(1023, {8'h00, 14'h1234, 2'b01}, 1'b0, 8'h39, 8'hFF); // R3 upper clamp
        repeat (40) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R2", "idle after start drops", adc_cs_n, 1);
        chk(sb_q.size() == 0, "R5", "results outstanding", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule